// File: doc/BRIEF.md
# Destination Address Filter with Match Table

This block makes the accept or reject decision for an incoming Ethernet frame from its 48-bit destination address. A receive path presents the six destination bytes together with a one-cycle check strobe; one clock later the block answers with an accept bit and a 16-bit type flag field. The flag field marks the frame as multicast or broadcast when one of those modes is the reason it was accepted.

The block holds a table of sixteen station addresses. A write port loads each entry one 16-bit word at a time, and a separate 16-bit enable mask decides which entries take part in matching. Three mode inputs sit beside the table: promiscuous, all-multicast and broadcast acceptance. The rules are tried in a fixed order, and the first rule that matches decides both the verdict and the flags.

While the surrounding controller holds the block in its reset mode, software can read the table back through three word ports, selecting the entry with a 4-bit pointer. Outside that mode, the read ports return zero.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `res_valid`, `res_accept` and `res_flags` are 0. Every table entry and every enable bit is 0, so with all modes off every check is rejected.
- R2: Destination byte k sits in `chk_addr[8k+7:8k]`. When `mode_promisc` is 1 and bit 0 of byte 0 is 0, the frame is accepted with flags 0x0000.
- R3: When `mode_allmcast` is 1 and bit 0 of byte 0 is 1, the frame is accepted with flags 0x0100. This rule ranks above the broadcast rule, so an all-ones address gets 0x0100 while this mode is on.
- R4: When `mode_bcast` is 1, `mode_allmcast` is 0 and the address is all ones, the frame is accepted with flags 0x0080.
- R5: When no earlier rule applies, an address equal to table entry i with enable bit i set is accepted with flags 0x0000. An entry whose enable bit is 0 never matches.
- R6: When no rule applies, the frame is rejected and the flags are 0x0000. `mode_promisc` on its own does not accept an address whose byte 0 has bit 0 set.
- R7: A table write with word select w (0, 1 or 2) stores `tbl_wr_data[7:0]` as address byte 2w and `tbl_wr_data[15:8]` as address byte 2w+1 of entry `tbl_wr_idx`. Word select 3 has no effect. A mask write replaces the whole enable mask, and bit i enables entry i.
- R8: While `in_reset_mode` is 1, `rd_word0`, `rd_word1` and `rd_word2` return words 0, 1 and 2 of entry `rd_ptr`, using the byte layout of R7. While it is 0, all three return 0.
- R9: The result appears in the cycle after the check strobe. `res_valid` is 1 for that one cycle, and `res_accept` and `res_flags` hold their value until the next check.
- R10: A table or mask write made in the same cycle as a check strobe does not affect that check. It does affect the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_idx | input | 4 | Entry to write |
| tbl_wr_word | input | 2 | Word of the entry to write (0..2) |
| tbl_wr_data | input | 16 | Word data; low byte is the earlier address byte |
| mask_wr_en | input | 1 | Enable-mask write strobe |
| mask_wr_data | input | 16 | New enable mask |
| mode_promisc | input | 1 | Accept unicast destinations |
| mode_allmcast | input | 1 | Accept every multicast destination |
| mode_bcast | input | 1 | Accept the broadcast destination |
| in_reset_mode | input | 1 | Controller reset mode; enables read-back |
| rd_ptr | input | 4 | Entry selected for read-back |
| rd_word0 | output | 16 | Bytes 1:0 of the selected entry |
| rd_word1 | output | 16 | Bytes 3:2 of the selected entry |
| rd_word2 | output | 16 | Bytes 5:4 of the selected entry |
| chk_valid | input | 1 | Check strobe |
| chk_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result strobe, one cycle after `chk_valid` |
| res_accept | output | 1 | Frame accepted |
| res_flags | output | 16 | Type flags: 0x0100 multicast, 0x0080 broadcast |

## Verification
The verdict and flags are registered, so the bench drives a check on a falling edge and compares `res_valid`, `res_accept` and `res_flags` on the next falling edge, half a cycle after the edge that loads them. It also confirms that `res_valid` has dropped one cycle later. Table and mask writes land on the rising edge inside their drive window, so the bench's model is updated after that edge. The same-cycle case of R10 is predicted from the model as it stood before the write. The read-back ports are combinational from the stored table, and the bench samples them on the falling edge after any write has settled.

// File: rtl/daf_pkg.sv
`timescale 1ns/1ps
package daf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int WORD_W     = 16;
    localparam int WORDS      = ADDR_W / WORD_W;
    localparam int FLAG_W     = 16;

    localparam logic [FLAG_W-1:0] FLAG_NONE  = 16'h0000;
    localparam logic [FLAG_W-1:0] FLAG_MCAST = 16'h0100;
    localparam logic [FLAG_W-1:0] FLAG_BCAST = 16'h0080;

    typedef logic [ADDR_W-1:0] mac_t;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_PROMISC,
        HIT_MCAST,
        HIT_BCAST,
        HIT_TABLE
    } hit_e;

    typedef struct packed {
        logic              valid;
        logic              accept;
        logic [FLAG_W-1:0] flags;
    } result_t;
endpackage

// File: rtl/daf_table.sv
`timescale 1ns/1ps
module daf_table
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [1:0]                  wr_word,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        mask_en,
    input  logic [ENTRIES-1:0]          mask_data,
    input  logic                        rd_allow,
    input  logic [IDX_W-1:0]            rd_ptr,
    output logic [WORDS-1:0][WORD_W-1:0] rd_words,
    output logic [ENTRIES-1:0][ADDR_W-1:0] ent,
    output logic [ENTRIES-1:0]          ena
);
    typedef struct packed {
        logic [ENTRIES-1:0][ADDR_W-1:0] ent;
        logic [ENTRIES-1:0]             ena;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_word == w[1:0]) begin
                    st_d.ent[wr_idx][w*WORD_W +: WORD_W] = wr_data;
                end
            end
        end
        if (mask_en) begin
            st_d.ena = mask_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_rd
            assign rd_words[w] = rd_allow ? st_q.ent[rd_ptr][w*WORD_W +: WORD_W] : '0;
        end
    endgenerate

    assign ent = st_q.ent;
    assign ena = st_q.ena;
endmodule

// File: rtl/daf_match.sv
`timescale 1ns/1ps
module daf_match
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  mac_t                          addr,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] ent,
    input  logic [ENTRIES-1:0]            ena,
    output logic                          any_hit
);
    logic [ENTRIES-1:0] hit;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign hit[i] = ena[i] && (ent[i] == addr);
        end
    endgenerate

    assign any_hit = |hit;
endmodule

// File: rtl/daf_rules.sv
`timescale 1ns/1ps
module daf_rules
    import daf_pkg::*;
(
    input  mac_t  addr,
    input  logic  promisc,
    input  logic  allmcast,
    input  logic  bcast,
    input  logic  table_hit,
    output hit_e  verdict
);
    logic group_bit;
    logic all_ones;

    assign group_bit = addr[0];
    assign all_ones  = &addr;

    always_comb begin
        if (promisc && !group_bit) begin
            verdict = HIT_PROMISC;
        end else if (allmcast && group_bit) begin
            verdict = HIT_MCAST;
        end else if (bcast && all_ones) begin
            verdict = HIT_BCAST;
        end else if (table_hit) begin
            verdict = HIT_TABLE;
        end else begin
            verdict = HIT_NONE;
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
`timescale 1ns/1ps
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic [1:0]        tbl_wr_word,
    input  logic [15:0]       tbl_wr_data,
    input  logic              mask_wr_en,
    input  logic [ENTRIES-1:0] mask_wr_data,
    input  logic              mode_promisc,
    input  logic              mode_allmcast,
    input  logic              mode_bcast,
    input  logic              in_reset_mode,
    input  logic [IDX_W-1:0]  rd_ptr,
    output logic [15:0]       rd_word0,
    output logic [15:0]       rd_word1,
    output logic [15:0]       rd_word2,
    input  logic              chk_valid,
    input  logic [47:0]       chk_addr,
    output logic              res_valid,
    output logic              res_accept,
    output logic [15:0]       res_flags
);
    logic [ENTRIES-1:0][ADDR_W-1:0] ent;
    logic [ENTRIES-1:0]             ena;
    logic [WORDS-1:0][WORD_W-1:0]   rd_words;
    logic                           any_hit;
    hit_e                           verdict;

    daf_table #(.ENTRIES(ENTRIES)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr_en),
        .wr_idx    (tbl_wr_idx),
        .wr_word   (tbl_wr_word),
        .wr_data   (tbl_wr_data),
        .mask_en   (mask_wr_en),
        .mask_data (mask_wr_data),
        .rd_allow  (in_reset_mode),
        .rd_ptr    (rd_ptr),
        .rd_words  (rd_words),
        .ent       (ent),
        .ena       (ena)
    );

    daf_match #(.ENTRIES(ENTRIES)) u_match (
        .addr    (chk_addr),
        .ent     (ent),
        .ena     (ena),
        .any_hit (any_hit)
    );

    daf_rules u_rules (
        .addr      (chk_addr),
        .promisc   (mode_promisc),
        .allmcast  (mode_allmcast),
        .bcast     (mode_bcast),
        .table_hit (any_hit),
        .verdict   (verdict)
    );

    result_t res_d, res_q;

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (chk_valid) begin
            res_d.valid = 1'b1;
            unique case (verdict)
                HIT_PROMISC, HIT_TABLE: begin
                    res_d.accept = 1'b1;
                    res_d.flags  = FLAG_NONE;
                end
                HIT_MCAST: begin
                    res_d.accept = 1'b1;
                    res_d.flags  = FLAG_MCAST;
                end
                HIT_BCAST: begin
                    res_d.accept = 1'b1;
                    res_d.flags  = FLAG_BCAST;
                end
                default: begin
                    res_d.accept = 1'b0;
                    res_d.flags  = FLAG_NONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid  = res_q.valid;
    assign res_accept = res_q.accept;
    assign res_flags  = res_q.flags;
    assign rd_word0   = rd_words[0];
    assign rd_word1   = rd_words[1];
    assign rd_word2   = rd_words[2];
endmodule

// File: rtl/daf_checker.sv
`timescale 1ns/1ps
module daf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_reset_mode,
    input logic [15:0] rd_word0,
    input logic [15:0] rd_word1,
    input logic [15:0] rd_word2,
    input logic        mode_promisc,
    input logic        mode_allmcast,
    input logic        mode_bcast,
    input logic        chk_valid,
    input logic [47:0] chk_addr,
    input logic        res_valid,
    input logic        res_accept,
    input logic [15:0] res_flags
);
    a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid);

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> ($stable(res_accept) && $stable(res_flags)));

    a_r2_promisc_unicast: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && mode_promisc && !chk_addr[0]) |=> (res_accept && res_flags == 16'h0000));

    a_r3_allmcast_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && mode_allmcast && chk_addr[0]) |=> (res_accept && res_flags == 16'h0100));

    a_r4_bcast_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && mode_bcast && !mode_allmcast && (&chk_addr)) |=>
        (res_accept && res_flags == 16'h0080));

    a_r6_reject_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept) |-> (res_flags == 16'h0000));

    a_r6_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0(res_flags));

    a_r8_readback_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset_mode |-> (rd_word0 == 16'h0 && rd_word1 == 16'h0 && rd_word2 == 16'h0));
endmodule

bind dst_addr_filter daf_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_reset_mode (in_reset_mode),
    .rd_word0      (rd_word0),
    .rd_word1      (rd_word1),
    .rd_word2      (rd_word2),
    .mode_promisc  (mode_promisc),
    .mode_allmcast (mode_allmcast),
    .mode_bcast    (mode_bcast),
    .chk_valid     (chk_valid),
    .chk_addr      (chk_addr),
    .res_valid     (res_valid),
    .res_accept    (res_accept),
    .res_flags     (res_flags)
);

// File: tb/tb_dst_addr_filter.sv
`timescale 1ns/1ps
module tb_dst_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [3:0]  tbl_wr_idx = '0;
    logic [1:0]  tbl_wr_word = '0;
    logic [15:0] tbl_wr_data = '0;
    logic        mask_wr_en = 1'b0;
    logic [15:0] mask_wr_data = '0;
    logic        mode_promisc = 1'b0;
    logic        mode_allmcast = 1'b0;
    logic        mode_bcast = 1'b0;
    logic        in_reset_mode = 1'b0;
    logic [3:0]  rd_ptr = '0;
    logic [15:0] rd_word0, rd_word1, rd_word2;
    logic        chk_valid = 1'b0;
    logic [47:0] chk_addr = '0;
    logic        res_valid, res_accept;
    logic [15:0] res_flags;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [47:0] m_ent [16];
    logic [15:0] m_ena;

    always #10 clk = ~clk;

    dst_addr_filter dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] model(input logic [47:0] a, input logic p, input logic m,
                                          input logic b);
        if (p && !a[0]) return {1'b1, 16'h0000};
        if (m && a[0]) return {1'b1, 16'h0100};
        if (b && (&a)) return {1'b1, 16'h0080};
        for (int i = 0; i < 16; i++)
            if (m_ena[i] && m_ent[i] == a) return {1'b1, 16'h0000};
        return {1'b0, 16'h0000};
    endfunction

    task automatic wr_word(input int idx, input int w, input logic [15:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = idx[3:0]; tbl_wr_word = w[1:0]; tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        if (w < 3) m_ent[idx][w*16 +: 16] = d;
    endtask

    task automatic wr_entry(input int idx, input logic [47:0] a);
        for (int w = 0; w < 3; w++) wr_word(idx, w, a[w*16 +: 16]);
    endtask

    task automatic wr_mask(input logic [15:0] mk);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_data = mk;
        @(negedge clk);
        mask_wr_en = 1'b0;
        m_ena = mk;
    endtask

    task automatic run_check(input string req, input logic [47:0] a, input logic p,
                             input logic m, input logic b);
        logic [16:0] e;
        e = model(a, p, m, b);
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = a;
        mode_promisc = p; mode_allmcast = m; mode_bcast = b;
        @(negedge clk);
        chk_valid = 1'b0;
        check(req, {res_valid, res_accept, res_flags}, {1'b1, e});
        @(negedge clk);
        check({req, " R9 hold"}, {res_valid, res_accept, res_flags}, {1'b0, e});
    endtask

    task automatic check_readback(input string req, input int idx, input logic en);
        @(negedge clk);
        in_reset_mode = en; rd_ptr = idx[3:0];
        #1;
        if (en) check(req, {rd_word2, rd_word1, rd_word0}, m_ent[idx]);
        else    check(req, {rd_word2, rd_word1, rd_word0}, 48'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        logic [16:0] e;
        void'($urandom(32'd12345));
        for (int i = 0; i < 16; i++) m_ent[i] = '0;
        m_ena = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset result", {res_valid, res_accept, res_flags}, 18'h0);
        check_readback("R1 reset table", 5, 1'b1);
        run_check("R1 empty table rejects", 48'h0, 1'b0, 1'b0, 1'b0);

        // R7 table load byte layout, R8 readback
        wr_entry(3, 48'h665544332211);
        check_readback("R7 R8 readback entry3", 3, 1'b1);
        @(negedge clk); in_reset_mode = 1'b1; rd_ptr = 4'd3; #1;
        check("R7 byte0 in low half", {56'h0, rd_word0[7:0]}, 64'h11);
        check("R7 byte1 in high half", {56'h0, rd_word0[15:8]}, 64'h22);
        wr_word(3, 3, 16'hBEEF);
        check_readback("R7 word select 3 ignored", 3, 1'b1);
        check_readback("R8 gated outside reset mode", 3, 1'b0);

        // R5 enable gating
        run_check("R5 disabled entry no match", 48'h665544332211, 1'b0, 1'b0, 1'b0);
        wr_mask(16'h0008);
        run_check("R5 enabled entry matches", 48'h665544332211, 1'b0, 1'b0, 1'b0);
        run_check("R6 near miss rejected", 48'h665544332210, 1'b0, 1'b0, 1'b0);

        // R2, R3, R4, R6 priorities
        run_check("R2 promisc unicast", 48'h0000000000AA, 1'b1, 1'b0, 1'b0);
        run_check("R6 promisc alone multicast", 48'h0000000000AB, 1'b1, 1'b0, 1'b0);
        run_check("R3 allmcast multicast", 48'h0000000000AB, 1'b0, 1'b1, 1'b0);
        run_check("R3 allmcast over broadcast", 48'hFFFFFFFFFFFF, 1'b0, 1'b1, 1'b1);
        run_check("R4 broadcast", 48'hFFFFFFFFFFFF, 1'b1, 1'b0, 1'b1);
        run_check("R6 broadcast mode off", 48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0);

        // R10 same-cycle write does not affect this check
        a = 48'h0A0B0C0D0E10;
        e = model(a, 1'b0, 1'b0, 1'b0);
        wr_entry(7, a);
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = a; mode_promisc = 0; mode_allmcast = 0; mode_bcast = 0;
        mask_wr_en = 1'b1; mask_wr_data = 16'h0088;
        @(negedge clk);
        chk_valid = 1'b0; mask_wr_en = 1'b0;
        check("R10 same-cycle mask write unseen", {res_valid, res_accept, res_flags}, {1'b1, e});
        m_ena = 16'h0088;
        run_check("R10 mask write seen next check", a, 1'b0, 1'b0, 1'b0);

        // constrained random
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op == 0) begin
                wr_word($urandom_range(0, 15), $urandom_range(0, 3), 16'($urandom));
            end else if (op == 1) begin
                wr_mask(16'($urandom));
            end else if (op == 2) begin
                check_readback("R8 random readback", $urandom_range(0, 15), 1'($urandom));
            end else begin
                int sel;
                sel = $urandom_range(0, 3);
                if (sel == 0) a = m_ent[$urandom_range(0, 15)];
                else if (sel == 1) a = 48'hFFFFFFFFFFFF;
                else a = {16'($urandom), 32'($urandom)};
                run_check("R2-6 random check", a, 1'($urandom), 1'($urandom), 1'($urandom));
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule